// File: doc/BRIEF.md
# CRT Sync Skew and Polarity Unit

This unit sits between a display timing generator and a CRT output stage. It receives a pixel word together with active-high horizontal and vertical sync pulses that are generated in lockstep with the pixels. It then moves both syncs relative to the pixel stream by a programmable number of pixel clocks, earlier or later. The move makes up for processing delay elsewhere in the video path. After the move, each sync gets its own output polarity.

Sync can only be moved earlier if the pixels are held back. So the pixel word always passes through a fixed baseline latency. The sync pair takes a tap from a delay line whose length is the value of a 3-bit skew code. The relative skew equals the code minus the baseline. Polarity is applied in the last register stage, after the skew tap, so it only changes levels and never changes when a pulse occurs.

Top module: `crt_sync_skew`

## Requirements
- R1: `pix_out` equals the `pix_in` value presented 5 clocks earlier. This is the fixed baseline latency of 4 plus one output register.
- R2: Skew codes 0, 1, 2 and 3 make the first active output sync cycle coincide with pixels that came 4, 3, 2 and 1 clocks before the input pulse's first pixel, respectively.
- R3: Skew code 4 is the baseline. An output sync pulse lines up with exactly the same pixels it accompanied at the input.
- R4: Skew codes 5, 6 and 7 make output sync coincide with pixels that came 1, 2 and 3 clocks after the input pulse's first pixel, respectively.
- R5: With `hsync_pol` = 0, `hsync_out` rests low and is high while the sync is active. With `hsync_pol` = 1, it rests high and is low while active. The pulse width is kept, and a polarity change appears on the output one clock later.
- R6: `vsync_pol` controls `vsync_out` in the same way, independently of `hsync_pol`.
- R7: While `rst` is high, `pix_out` is 0 and each sync output sits at its resting level. Reset also empties both delay lines, so after release the next 4 `pix_out` values are 0 and the syncs stay at rest until a new input pulse arrives.
- R8: Horizontal and vertical sync are moved by the same amount for any code, and each keeps its input pulse width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | DATA_W (24) | Pixel word from the timing generator |
| hsync_in | input | 1 | Active-high horizontal sync, aligned to `pix_in` |
| vsync_in | input | 1 | Active-high vertical sync, aligned to `pix_in` |
| skew_code | input | CODE_W (3) | Sync delay in clocks; 4 is the baseline |
| hsync_pol | input | 1 | 1 inverts `hsync_out` |
| vsync_pol | input | 1 | 1 inverts `vsync_out` |
| pix_out | output | DATA_W (24) | Pixel word after the baseline latency |
| hsync_out | output | 1 | Skewed horizontal sync at the selected polarity |
| vsync_out | output | 1 | Skewed vertical sync at the selected polarity |

## Verification
The hardest case to reach from the ports is an exact pixel-to-sync offset, because it can only be measured by the relation between two outputs and never from one alone. The stimulus drives a free-running pixel counter as data. For every skew code, it then records which counter value is on `pix_out` in the first cycle the output sync turns active, so the offset can be read directly as a number. Each code is measured after an idle flush, so that only steady-state alignment is judged. The two polarity bits are varied across codes, which tests the active-level detection with both resting levels.

// File: rtl/crt_skew_pkg.sv
package crt_skew_pkg;

    typedef struct packed {
        logic hs;
        logic vs;
    } sync_pair_t;

    localparam sync_pair_t SYNC_INACTIVE = '{hs: 1'b0, vs: 1'b0};

    // Centre code of an offset-binary skew field: delay of the baseline.
    function automatic int unsigned centre_code(input int unsigned code_w);
        return 32'd1 << (code_w - 1);
    endfunction

    // Convert active-high internal sync into pin levels.
    function automatic sync_pair_t to_pin_level(input sync_pair_t s,
                                                input logic inv_h,
                                                input logic inv_v);
        sync_pair_t r;
        r.hs = s.hs ^ inv_h;
        r.vs = s.vs ^ inv_v;
        return r;
    endfunction

endpackage

// File: rtl/pixel_fixed_delay.sv
module pixel_fixed_delay #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned DEPTH  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] stage [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= data_in;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign data_out = stage[DEPTH-1];

    logic warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    // R7: the cycle after reset releases, the line shows only cleared data
    a_r7_pix_cleared: assert property (@(posedge clk) disable iff (rst)
        !warm |-> data_out == '0);

endmodule

// File: rtl/sync_tap_delay.sv
module sync_tap_delay
    import crt_skew_pkg::*;
#(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_pair_t        sync_in,
    input  logic [CODE_W-1:0] code,
    output sync_pair_t        sync_tap
);
    localparam int unsigned NTAP = 1 << CODE_W;

    sync_pair_t taps [NTAP];

    assign taps[0] = sync_in;

    generate
        for (genvar i = 1; i < NTAP; i++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) taps[i] <= SYNC_INACTIVE;
                else     taps[i] <= taps[i-1];
            end
        end
    endgenerate

    assign sync_tap = taps[code];

    logic warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    // R2: code 0 takes the sync with no line delay
    a_r2_tap_zero: assert property (@(posedge clk) disable iff (rst)
        (code == '0) |-> sync_tap == sync_in);

    // R2: code 1 yields the sync seen one clock earlier
    a_r2_tap_one: assert property (@(posedge clk) disable iff (rst)
        (warm && code == CODE_W'(1)) |-> sync_tap == $past(sync_in));

    // R7: directly after reset the line holds no active sync
    a_r7_line_empty: assert property (@(posedge clk) disable iff (rst)
        (!warm && code != '0) |-> sync_tap == SYNC_INACTIVE);

endmodule

// File: rtl/sync_polarity_stage.sv
module sync_polarity_stage
    import crt_skew_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sync_pair_t sync_in,
    input  logic       inv_h,
    input  logic       inv_v,
    output logic       hs_pin,
    output logic       vs_pin
);
    sync_pair_t pin_q;

    always_ff @(posedge clk) begin
        if (rst) pin_q <= to_pin_level(SYNC_INACTIVE, inv_h, inv_v);
        else     pin_q <= to_pin_level(sync_in, inv_h, inv_v);
    end

    assign hs_pin = pin_q.hs;
    assign vs_pin = pin_q.vs;

    logic warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= 1'b0;
        else     warm <= 1'b1;
    end

    // R5: with steady sync and polarity, the pin level does not move
    a_r5_level_steady: assert property (@(posedge clk) disable iff (rst)
        (warm && $stable(sync_in) && $stable(inv_h) && $stable(inv_v))
            |=> ($stable(hs_pin) && $stable(vs_pin)));

    // R7: leaving reset, each pin rests at the level its polarity gives
    a_r7_rest_level: assert property (@(posedge clk) disable iff (rst)
        !warm |-> (hs_pin == $past(inv_h) && vs_pin == $past(inv_v)));

endmodule

// File: rtl/crt_sync_skew.sv
module crt_sync_skew
    import crt_skew_pkg::*;
#(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pix_in,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic [CODE_W-1:0] skew_code,
    input  logic              hsync_pol,
    input  logic              vsync_pol,
    output logic [DATA_W-1:0] pix_out,
    output logic              hsync_out,
    output logic              vsync_out
);
    localparam int unsigned BASE_LAT = centre_code(CODE_W);
    localparam int unsigned PIX_LAT  = BASE_LAT + 1;

    sync_pair_t sync_raw;
    sync_pair_t sync_tapped;

    assign sync_raw.hs = hsync_in;
    assign sync_raw.vs = vsync_in;

    pixel_fixed_delay #(
        .DATA_W (DATA_W),
        .DEPTH  (PIX_LAT)
    ) u_pix_dly (
        .clk      (clk),
        .rst      (rst),
        .data_in  (pix_in),
        .data_out (pix_out)
    );

    sync_tap_delay #(
        .CODE_W (CODE_W)
    ) u_sync_dly (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_raw),
        .code     (skew_code),
        .sync_tap (sync_tapped)
    );

    sync_polarity_stage u_pol (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_tapped),
        .inv_h   (hsync_pol),
        .inv_v   (vsync_pol),
        .hs_pin  (hsync_out),
        .vs_pin  (vsync_out)
    );

    generate
        if (PIX_LAT == 5) begin : g_lat_chk
            logic [2:0] run_cnt;
            always_ff @(posedge clk) begin
                if (rst)                run_cnt <= '0;
                else if (run_cnt != 3'd5) run_cnt <= run_cnt + 3'd1;
            end

            // R1: pixel word emerges five clocks after it entered
            a_r1_pix_latency: assert property (@(posedge clk) disable iff (rst)
                (run_cnt == 3'd5) |-> pix_out == $past(pix_in, 5));
        end
    endgenerate

endmodule

// File: tb/crt_sync_skew_bench.sv
module crt_sync_skew_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 24;
    localparam int CW = 3;

    // {code[8:6], hpol[5], vpol[4], expected pixel offset (signed)[3:0]}
    localparam logic [8:0] VEC [9] = '{
        {3'd0, 1'b0, 1'b0, 4'hC},
        {3'd1, 1'b1, 1'b0, 4'hD},
        {3'd2, 1'b0, 1'b1, 4'hE},
        {3'd3, 1'b1, 1'b1, 4'hF},
        {3'd4, 1'b0, 1'b0, 4'h0},
        {3'd5, 1'b1, 1'b0, 4'h1},
        {3'd6, 1'b0, 1'b1, 4'h2},
        {3'd7, 1'b1, 1'b1, 4'h3},
        {3'd4, 1'b1, 1'b1, 4'h0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] pix_in = '0;
    logic          hsync_in = 1'b0;
    logic          vsync_in = 1'b0;
    logic [CW-1:0] skew_code = 3'd4;
    logic          hsync_pol = 1'b1;
    logic          vsync_pol = 1'b0;
    logic [DW-1:0] pix_out;
    logic          hsync_out;
    logic          vsync_out;

    int checks = 0;
    int errors = 0;
    int n = 100;
    bit finished = 1'b0;

    logic [DW-1:0] o_pix;
    logic          o_hs;
    logic          o_vs;

    always #(CLK_PERIOD / 2) clk = ~clk;

    crt_sync_skew #(.DATA_W(DW), .CODE_W(CW)) u_crt_sync_skew (
        .clk       (clk),
        .rst       (rst),
        .pix_in    (pix_in),
        .hsync_in  (hsync_in),
        .vsync_in  (vsync_in),
        .skew_code (skew_code),
        .hsync_pol (hsync_pol),
        .vsync_pol (vsync_pol),
        .pix_out   (pix_out),
        .hsync_out (hsync_out),
        .vsync_out (vsync_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sample outputs at the falling edge, then drive the next pixel.
    task automatic step(input logic hs, input logic vs);
        @(negedge clk);
        o_pix = pix_out;
        o_hs  = hsync_out;
        o_vs  = vsync_out;
        pix_in   = DW'(n);
        hsync_in = hs;
        vsync_in = vs;
        n++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // ---- table-driven skew and polarity sweep (after a plain reset) ----
        pix_in = 24'd55;
        hsync_in = 1'b1;
        vsync_in = 1'b1;
        repeat (3) @(negedge clk);
        // R7: outputs held at rest during reset despite active inputs
        check(pix_out == '0, "R7 reset pix", int'(pix_out), 0);
        check(hsync_out == 1'b1, "R7 reset hsync rest", hsync_out, 1);
        check(vsync_out == 1'b0, "R7 reset vsync rest", vsync_out, 0);
        hsync_in = 1'b0;
        vsync_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        pix_in = DW'(n);
        n++;
        begin
            int zeros = 0;
            int rest_bad = 0;
            for (int i = 0; i < 4; i++) begin
                step(1'b0, 1'b0);
                if (o_pix == '0) zeros++;
                if (o_hs != 1'b1 || o_vs != 1'b0) rest_bad++;
            end
            check(zeros == 4, "R7 cleared pixel line", zeros, 4);
            check(rest_bad == 0, "R7 syncs at rest after release", rest_bad, 0);
        end

        for (int k = 0; k < 9; k++) begin
            int code;
            int exp_off;
            int hs_first;
            int vs_first;
            int hs_w;
            int vs_w;
            int pix_bad;
            int hk;
            int vk;
            string tag;
            code = int'(VEC[k][8:6]);
            exp_off = int'($signed(VEC[k][3:0]));
            tag = (code < 4) ? "R2" : ((code == 4) ? "R3" : "R4");
            @(negedge clk);
            skew_code = VEC[k][8:6];
            hsync_pol = VEC[k][5];
            vsync_pol = VEC[k][4];
            for (int i = 0; i < 12; i++) step(1'b0, 1'b0);
            check(o_hs == hsync_pol, "R5 hsync resting level", o_hs, hsync_pol);
            check(o_vs == vsync_pol, "R6 vsync resting level", o_vs, vsync_pol);
            hs_first = -1;
            vs_first = -1;
            hs_w = 0;
            vs_w = 0;
            pix_bad = 0;
            hk = 0;
            vk = 0;
            for (int i = 0; i < 40; i++) begin
                if (i == 10) hk = n;
                if (i == 15) vk = n;
                step(i >= 10 && i < 13, i >= 15 && i < 19);
                if (i > 0 && o_pix != DW'(n - 6)) pix_bad++;
                if (o_hs != hsync_pol) begin
                    hs_w++;
                    if (hs_first < 0) hs_first = int'(o_pix);
                end
                if (o_vs != vsync_pol) begin
                    vs_w++;
                    if (vs_first < 0) vs_first = int'(o_pix);
                end
            end
            check(pix_bad == 0, "R1 pixel latency", pix_bad, 0);
            check(hs_first == hk + exp_off, {tag, " hsync pixel offset"}, hs_first - hk, exp_off);
            check(vs_first == vk + exp_off, "R8 vsync offset matches", vs_first - vk, exp_off);
            check(hs_w == 3, "R5 hsync pulse width", hs_w, 3);
            check(vs_w == 4, "R6 vsync pulse width", vs_w, 4);
        end

        // ---- directed: polarity change reaches the pin one clock later ----
        @(negedge clk);
        skew_code = 3'd4;
        hsync_pol = 1'b0;
        vsync_pol = 1'b1;
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        hsync_pol = 1'b1;
        step(1'b0, 1'b0);
        check(o_hs == 1'b1, "R5 polarity flip next clock", o_hs, 1);
        check(o_vs == 1'b1, "R6 vsync unaffected by hsync_pol", o_vs, 1);

        // ---- directed: reset in mid-pulse flushes the lines ----
        skew_code = 3'd7;
        hsync_pol = 1'b0;
        vsync_pol = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
        rst = 1'b1;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        rst = 1'b0;
        begin
            int act = 0;
            for (int i = 0; i < 10; i++) begin
                step(1'b0, 1'b0);
                if (o_hs || o_vs) act++;
            end
            check(act == 0, "R7 reset drops pulses in flight", act, 0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule